// File: doc/BRIEF.md
# Card Management Register File

This block is the small control and status register set that a flash card controller exposes in its attribute address space. The bus steering logic hands it decoded attribute reads and writes (a byte-wide data path with an even byte address). It keeps a software reset flag, a whole-card power-down flag, two write-protect enables (one for the first block pair of common memory, one for the rest), a per-device-pair sleep vector and a per-device-pair ready/busy mask vector. A read-only status byte is assembled live from these registers, from the mechanical write-protect switch and from the combined ready/busy state of the device pairs.

Toward the flash array the block produces one access enable per device pair and a qualified write grant. The steering block presents an array write request with the target pair index and a flag that tells whether the target lies in the first block pair. The grant is refused when the switch is set, when the card is held in software reset or powered down, when the target pair sleeps, or when the region it hits is protected. Protection only ever gates the array. Register writes always go through.

Top module: `card_mgmt_regs`

## Requirements
- R1: After hardware reset every register reads 0x00, all pair access enables are high and the status byte holds only the switch state in bit 1 and the card ready state in bit 0.
- R2: The configuration register at offset 0x4000 holds the soft reset flag in bit 7, and bits 6..0 always read 0. Writing a 1 to bit 7 sets the flag and, in the same write, returns the power-down, write-protect, sleep and mask registers to 0. Writing a 0 clears the flag.
- R3: While the soft reset flag is set, writes to every register other than 0x4000 are ignored, all pair access enables are low and no array write is granted.
- R4: The power-down register at 0x4002 holds its flag in bit 2, and its other bits read 0. When set, all pair access enables are low. Setting or clearing it leaves the sleep vector unchanged.
- R5: The status byte at 0x4100 reads as: bit 0 card ready, bit 1 switch, bit 2 first-block protect, bit 3 card asleep, bit 4 common-memory protect, bit 5 soft reset, bit 6 any pair asleep, bit 7 any pair masked. Writes to 0x4100 are ignored.
- R6: Status bit 3 is 1 when the power-down flag is set or when every pair's sleep bit is set.
- R7: The write-protect register at 0x4104 holds first-block protection in bit 0 and common-memory protection in bit 1, and bits 7..2 read 0.
- R8: The sleep register at 0x4108 and the mask register at 0x410C hold one bit per pair, with bit i for pair i. Bits at and above the pair count read 0. A pair's access enable is low while its sleep bit is set.
- R9: Card ready is the AND over all pairs of (pair ready OR pair mask bit), so masked pairs count as ready.
- R10: An array write is granted exactly when it is requested, the switch is low, soft reset and power-down are clear, the target pair is awake, and the target region is unprotected. The first block pair uses bit 0 of 0x4104, and every other address uses bit 1.
- R11: A high switch does not block register writes.
- R12: A read of an unmapped offset, or any cycle without a read strobe, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| reg_wr | input | 1 | Attribute register write strobe |
| reg_rd | input | 1 | Attribute register read strobe |
| reg_addr | input | 15 | Attribute byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, 0 without strobe |
| wp_switch | input | 1 | Mechanical write-protect switch, high = protected |
| pair_ready | input | NUM_PAIRS | Per-pair ready output of the devices, high = ready |
| arr_wr_req | input | 1 | Array write request from the steering block |
| arr_pair | input | PAIR_IDX_W | Device pair targeted by the request |
| arr_first_blk | input | 1 | Request targets the first common-memory block pair |
| arr_wr_ok | output | 1 | Qualified array write grant |
| pair_en | output | NUM_PAIRS | Per-pair access enable (awake) |
| card_ready | output | 1 | Combined card ready/busy, high = ready |

## Verification
The ready logic is swept over every pairing of mask vector and pair-ready vector, which separates a mask that covers a busy pair from one that does not, and checks the status read at the same time. Every sleep vector is written and read back through the status byte, which separates the any-asleep OR from the all-asleep AND of bit 3. The write grant is swept over every combination of switch, both protect bits, power-down, a sleep pattern, target pair and region flag, which shows which protect bit a region uses. Soft reset sequences show that registers are cleared, that writes are blocked while the flag is held, and that writing the flag back to 0 releases the card.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    localparam int ATTR_AW   = 15;
    localparam int MAX_PAIRS = 8;

    localparam logic [ATTR_AW-1:0] OFS_CFG    = 15'h4000;
    localparam logic [ATTR_AW-1:0] OFS_PWR    = 15'h4002;
    localparam logic [ATTR_AW-1:0] OFS_STATUS = 15'h4100;
    localparam logic [ATTR_AW-1:0] OFS_PROT   = 15'h4104;
    localparam logic [ATTR_AW-1:0] OFS_SLEEP  = 15'h4108;
    localparam logic [ATTR_AW-1:0] OFS_MASK   = 15'h410C;

    // bit positions that software decodes
    localparam int BIT_SRST     = 7;
    localparam int BIT_PDN      = 2;
    localparam int BIT_PROT_CIS = 0;
    localparam int BIT_PROT_CM  = 1;

    typedef struct packed {
        logic                 srst;
        logic                 pdn;
        logic                 prot_cis;
        logic                 prot_cm;
        logic [MAX_PAIRS-1:0] sleep;
        logic [MAX_PAIRS-1:0] mask;
    } cmr_regs_t;

    localparam cmr_regs_t CMR_DEFAULT = '0;

endpackage

// File: rtl/cmr_ctrl_regs.sv
module cmr_ctrl_regs
    import cmr_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ATTR_AW-1:0] reg_addr,
    input  logic [7:0]         reg_wdata,
    output cmr_regs_t          regs
);

    localparam logic [MAX_PAIRS-1:0] PAIR_MASK = MAX_PAIRS'((1 << NUM_PAIRS) - 1);

    cmr_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (reg_addr == OFS_CFG) begin
                st_d.srst = reg_wdata[BIT_SRST];
                if (reg_wdata[BIT_SRST]) begin
                    st_d          = CMR_DEFAULT;
                    st_d.srst     = 1'b1;
                end
            end else if (!st_q.srst) begin
                case (reg_addr)
                    OFS_PWR:   st_d.pdn = reg_wdata[BIT_PDN];
                    OFS_PROT: begin
                        st_d.prot_cis = reg_wdata[BIT_PROT_CIS];
                        st_d.prot_cm  = reg_wdata[BIT_PROT_CM];
                    end
                    OFS_SLEEP: st_d.sleep = reg_wdata & PAIR_MASK;
                    OFS_MASK:  st_d.mask  = reg_wdata & PAIR_MASK;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMR_DEFAULT;
        else        st_q <= st_d;
    end

    assign regs = st_q;

    // R2
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CFG && reg_wdata[BIT_SRST]) |=>
        (st_q.srst && !st_q.pdn && !st_q.prot_cis && !st_q.prot_cm &&
         st_q.sleep == '0 && st_q.mask == '0));

    // R3
    srst_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.srst && reg_wr && reg_addr != OFS_CFG) |=>
        ($stable(st_q.prot_cis) && $stable(st_q.prot_cm) && $stable(st_q.sleep)));

    // R4
    pdn_keeps_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_PWR) |=> $stable(st_q.sleep));

    // R8
    sleep_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.sleep & ~PAIR_MASK) == '0 && (st_q.mask & ~PAIR_MASK) == '0));

endmodule

// File: rtl/cmr_array_gate.sv
module cmr_array_gate #(
    parameter int NUM_PAIRS  = 4,
    parameter int PAIR_IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  srst,
    input  logic                  pdn,
    input  logic                  prot_cis,
    input  logic                  prot_cm,
    input  logic [NUM_PAIRS-1:0]  sleep,
    input  logic [NUM_PAIRS-1:0]  mask,
    input  logic [NUM_PAIRS-1:0]  pair_ready,
    input  logic                  wp_switch,
    input  logic                  arr_wr_req,
    input  logic [PAIR_IDX_W-1:0] arr_pair,
    input  logic                  arr_first_blk,
    output logic [NUM_PAIRS-1:0]  pair_en,
    output logic                  card_ready,
    output logic                  arr_wr_ok
);

    logic [NUM_PAIRS-1:0] pair_ok;
    logic                 region_prot;
    logic                 tgt_awake;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        assign pair_en[i] = !srst && !pdn && !sleep[i];
        assign pair_ok[i] = pair_ready[i] || mask[i];
    end

    assign card_ready  = &pair_ok;
    assign region_prot = arr_first_blk ? prot_cis : prot_cm;
    assign tgt_awake   = (int'(arr_pair) < NUM_PAIRS) ? pair_en[arr_pair] : 1'b0;
    assign arr_wr_ok   = arr_wr_req && !wp_switch && tgt_awake && !region_prot;

    // R10
    grant_needs_switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> (!wp_switch && !srst && !pdn));

    // R9
    all_masked_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> card_ready);

    // R3
    srst_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |-> (pair_en == '0 && !arr_wr_ok));

endmodule

// File: rtl/cmr_status_mux.sv
module cmr_status_mux
    import cmr_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmr_regs_t          regs,
    input  logic               card_ready,
    input  logic               wp_switch,
    input  logic               reg_rd,
    input  logic [ATTR_AW-1:0] reg_addr,
    output logic [7:0]         reg_rdata
);

    logic [7:0] status_byte;
    logic       all_asleep;
    logic [7:0] rd_mux;

    assign all_asleep = &regs.sleep[NUM_PAIRS-1:0];

    always_comb begin
        status_byte    = '0;
        status_byte[0] = card_ready;
        status_byte[1] = wp_switch;
        status_byte[2] = regs.prot_cis;
        status_byte[3] = regs.pdn || all_asleep;
        status_byte[4] = regs.prot_cm;
        status_byte[5] = regs.srst;
        status_byte[6] = |regs.sleep;
        status_byte[7] = |regs.mask;
    end

    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            OFS_CFG:    rd_mux[BIT_SRST] = regs.srst;
            OFS_PWR:    rd_mux[BIT_PDN]  = regs.pdn;
            OFS_STATUS: rd_mux = status_byte;
            OFS_PROT: begin
                rd_mux[BIT_PROT_CIS] = regs.prot_cis;
                rd_mux[BIT_PROT_CM]  = regs.prot_cm;
            end
            OFS_SLEEP:  rd_mux = 8'(regs.sleep);
            OFS_MASK:   rd_mux = 8'(regs.mask);
            default:    rd_mux = '0;
        endcase
    end

    assign reg_rdata = reg_rd ? rd_mux : 8'h00;

    // R6
    asleep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_STATUS && regs.sleep[NUM_PAIRS-1:0] == '1) |-> reg_rdata[3]);

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == 8'h00));

endmodule

// File: rtl/card_mgmt_regs.sv
module card_mgmt_regs
    import cmr_pkg::*;
#(
    parameter int NUM_PAIRS  = 4,
    parameter int PAIR_IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ATTR_AW-1:0]    reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  wp_switch,
    input  logic [NUM_PAIRS-1:0]  pair_ready,
    input  logic                  arr_wr_req,
    input  logic [PAIR_IDX_W-1:0] arr_pair,
    input  logic                  arr_first_blk,
    output logic                  arr_wr_ok,
    output logic [NUM_PAIRS-1:0]  pair_en,
    output logic                  card_ready
);

    cmr_regs_t regs;

    cmr_ctrl_regs #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .regs      (regs)
    );

    cmr_array_gate #(.NUM_PAIRS(NUM_PAIRS), .PAIR_IDX_W(PAIR_IDX_W)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .srst          (regs.srst),
        .pdn           (regs.pdn),
        .prot_cis      (regs.prot_cis),
        .prot_cm       (regs.prot_cm),
        .sleep         (regs.sleep[NUM_PAIRS-1:0]),
        .mask          (regs.mask[NUM_PAIRS-1:0]),
        .pair_ready    (pair_ready),
        .wp_switch     (wp_switch),
        .arr_wr_req    (arr_wr_req),
        .arr_pair      (arr_pair),
        .arr_first_blk (arr_first_blk),
        .pair_en       (pair_en),
        .card_ready    (card_ready),
        .arr_wr_ok     (arr_wr_ok)
    );

    cmr_status_mux #(.NUM_PAIRS(NUM_PAIRS)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs       (regs),
        .card_ready (card_ready),
        .wp_switch  (wp_switch),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_rdata  (reg_rdata)
    );

    // R11
    switch_no_reg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_switch && reg_wr && reg_addr == OFS_MASK && !regs.srst) |=>
        (regs.mask == MAX_PAIRS'($past(reg_wdata) & ((1 << NUM_PAIRS) - 1))));

endmodule

// File: tb/card_mgmt_regs_test.sv
`timescale 1ns/1ps
module card_mgmt_regs_test;

    localparam int NP = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [14:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          wp_switch = 1'b0;
    logic [NP-1:0] pair_ready = '1;
    logic          arr_wr_req = 1'b0;
    logic [IW-1:0] arr_pair = '0;
    logic          arr_first_blk = 1'b0;
    logic          arr_wr_ok;
    logic [NP-1:0] pair_en;
    logic          card_ready;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    card_mgmt_regs #(.NUM_PAIRS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wp_switch(wp_switch), .pair_ready(pair_ready), .arr_wr_req(arr_wr_req),
        .arr_pair(arr_pair), .arr_first_blk(arr_first_blk), .arr_wr_ok(arr_wr_ok),
        .pair_en(pair_en), .card_ready(card_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] stat_exp(input logic rdy, input logic sw, input logic cis,
        input logic pdn, input logic cm, input logic sr, input logic [NP-1:0] sl,
        input logic [NP-1:0] mk);
        return {|mk, |sl, sr, cm, pdn | (&sl), cis, sw, rdy};
    endfunction

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset defaults
        rd(15'h4000, v); chk("R1 cfg", v, 0);
        rd(15'h4002, v); chk("R1 pwr", v, 0);
        rd(15'h4104, v); chk("R1 prot", v, 0);
        rd(15'h4108, v); chk("R1 sleep", v, 0);
        rd(15'h410C, v); chk("R1 mask", v, 0);
        rd(15'h4100, v); chk("R1 status", v, 8'h01);
        chk("R1 pair_en", pair_en, 4'hF);

        // R9 + R5 bits 0/7: every mask against every ready pattern
        for (int m = 0; m < 16; m++) begin
            wr(15'h410C, 8'(m));
            for (int r = 0; r < 16; r++) begin
                logic e;
                pair_ready = 4'(r);
                e = &(4'(r) | 4'(m));
                rd(15'h4100, v);
                chk("R9 card_ready", card_ready, e);
                chk("R5 status ready/mask", v, stat_exp(e, 0, 0, 0, 0, 0, 0, 4'(m)));
            end
        end
        pair_ready = '1;
        wr(15'h410C, 8'h00);

        // R6 + R8 sleep sweep
        for (int s = 0; s < 16; s++) begin
            wr(15'h4108, 8'(s));
            rd(15'h4108, v); chk("R8 sleep readback", v, s);
            rd(15'h4100, v); chk("R6 status sleep", v, stat_exp(1, 0, 0, 0, 0, 0, 4'(s), 0));
            chk("R8 pair_en", pair_en, (~s) & 4'hF);
        end
        wr(15'h4108, 8'hFF); rd(15'h4108, v); chk("R8 sleep upper bits", v, 8'h0F);
        wr(15'h410C, 8'hF0); rd(15'h410C, v); chk("R8 mask upper bits", v, 8'h00);

        // R4 power-down
        wr(15'h4108, 8'h05);
        wr(15'h4002, 8'hFF);
        rd(15'h4002, v); chk("R4 pwr readback", v, 8'h04);
        rd(15'h4108, v); chk("R4 sleep kept", v, 8'h05);
        chk("R4 pair_en off", pair_en, 0);
        rd(15'h4100, v); chk("R6 status pdn", v, stat_exp(1, 0, 0, 1, 0, 0, 4'h5, 0));
        wr(15'h4002, 8'h00);
        rd(15'h4108, v); chk("R4 sleep kept after clear", v, 8'h05);
        chk("R4 pair_en back", pair_en, 4'hA);
        wr(15'h4108, 8'h00);

        // R7 protect register, R5 status write ignored
        wr(15'h4104, 8'hFF);
        rd(15'h4104, v); chk("R7 prot readback", v, 8'h03);
        wr(15'h4100, 8'h00);
        rd(15'h4100, v); chk("R5 status write ignored", v, stat_exp(1, 0, 1, 0, 1, 0, 0, 0));
        wr(15'h4104, 8'h01);
        rd(15'h4100, v); chk("R7 cis only", v, stat_exp(1, 0, 1, 0, 0, 0, 0, 0));

        // R11 switch does not block register writes
        wp_switch = 1'b1;
        wr(15'h410C, 8'h03);
        rd(15'h410C, v); chk("R11 mask write with switch", v, 8'h03);
        rd(15'h4100, v); chk("R11 status switch", v, stat_exp(1, 1, 1, 0, 0, 0, 0, 4'h3));
        wr(15'h410C, 8'h00);
        wr(15'h4104, 8'h00);
        wp_switch = 1'b0;

        // R10 write grant sweep
        for (int sw = 0; sw < 2; sw++)
        for (int pb = 0; pb < 4; pb++)
        for (int pd = 0; pd < 2; pd++)
        for (int sp = 0; sp < 2; sp++) begin
            logic [3:0] sl;
            sl = sp ? 4'b0101 : 4'b0000;
            wp_switch = sw[0];
            wr(15'h4104, 8'(pb));
            wr(15'h4002, pd ? 8'h04 : 8'h00);
            wr(15'h4108, 8'(sl));
            for (int p = 0; p < NP; p++)
            for (int fb = 0; fb < 2; fb++)
            for (int rq = 0; rq < 2; rq++) begin
                logic e;
                @(negedge clk);
                arr_pair = IW'(p); arr_first_blk = fb[0]; arr_wr_req = rq[0];
                e = rq[0] && !sw[0] && !pd[0] && !sl[p] && !(fb[0] ? pb[0] : pb[1]);
                #1 chk("R10 arr_wr_ok", arr_wr_ok, e);
            end
        end
        wp_switch = 1'b0;
        arr_wr_req = 1'b0;
        wr(15'h4002, 8'h00);

        // R2 / R3 soft reset
        wr(15'h4104, 8'h03);
        wr(15'h4108, 8'h02);
        wr(15'h410C, 8'h04);
        wr(15'h4000, 8'h80);
        rd(15'h4000, v); chk("R2 cfg flag", v, 8'h80);
        rd(15'h4104, v); chk("R2 prot cleared", v, 0);
        rd(15'h4108, v); chk("R2 sleep cleared", v, 0);
        rd(15'h410C, v); chk("R2 mask cleared", v, 0);
        rd(15'h4100, v); chk("R2 status srst", v, stat_exp(1, 0, 0, 0, 0, 1, 0, 0));
        chk("R3 pair_en off", pair_en, 0);
        @(negedge clk);
        arr_wr_req = 1'b1; arr_pair = 0; arr_first_blk = 1'b0;
        #1 chk("R3 no grant", arr_wr_ok, 0);
        arr_wr_req = 1'b0;
        wr(15'h4104, 8'h03);
        rd(15'h4104, v); chk("R3 prot write ignored", v, 0);
        wr(15'h4002, 8'h04);
        rd(15'h4002, v); chk("R3 pwr write ignored", v, 0);
        wr(15'h4000, 8'h7F);
        rd(15'h4000, v); chk("R2 low bits zero, flag cleared", v, 0);
        chk("R2 pair_en released", pair_en, 4'hF);
        wr(15'h4104, 8'h02);
        rd(15'h4104, v); chk("R3 writes resume", v, 8'h02);

        // R12 unmapped and idle reads
        rd(15'h4004, v); chk("R12 unmapped", v, 0);
        rd(15'h4106, v); chk("R12 unmapped 2", v, 0);
        @(negedge clk);
        reg_addr = 15'h4104;
        #1 chk("R12 no strobe", reg_rdata, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule